// File: doc/BRIEF.md
# Host-to-PCI Bridge Control Register Block

This block holds the control registers of a bridge that connects a host register bus to a PCI segment with only one device on it. Software reads a fixed 16-byte ASCII identification string, one character per byte offset, to recognise the bridge. It then writes a 32-bit magic key to the unlock register. A built-in delay follows. Only when the delay has run out does the block accept writes to its two window registers, its DMA base and end registers and its two enable bits.

The block also sits in the path of configuration accesses. An access to bus 0, device/function 0 goes through to the attached device, with its read data trimmed to the access width. An access to any other target gets all ones at the access width, and its write is dropped. A comparator tells whether a DMA address falls inside the programmed window. This comparator is held off until the DMA enable is set.

The unlock sequencer has three named states:
- `ST_LOCKED`: the reset state.
- `ST_ARMING`: the delay is counting.
- `ST_OPEN`: registers are writable.

Its transitions are:
- `key_write` (`ST_LOCKED` to `ST_ARMING`, on a write of the key).
- `delay_done` (`ST_ARMING` to `ST_OPEN`, when the counter has expired).
- `restart` (`ST_ARMING` to `ST_ARMING`, when the key is written again and the counter reloads).
- `rekey` (`ST_OPEN` to `ST_ARMING`, on a key write; this also clears every window and enable register).

Top module: `bridge_ctl`

## Requirements
- R1: A read of byte offset i, for i from 0x00 to 0x0F, returns character i of the identification string "HOSTBUS-PCI-BR01" in bits 7:0, with zeros above. Character 0 is the leftmost.
- R2: A write of 0x5A14A501 to offset 0x18 in the locked state starts the delay. Offset 0x18 reads 0 until UNLOCK_DELAY clock edges after the write edge, and reads 1 from then on.
- R3: A write of any other value to offset 0x18 leaves the state as it is. When locked, offset 0x18 keeps reading 0. When open, it keeps reading 1.
- R4: Until the unlock completes (locked or arming), writes to offsets 0x14, 0x20, 0x24, 0x28, 0x2C and 0x34 are ignored.
- R5: Once open, offsets 0x20, 0x24, 0x28 and 0x2C store and read back full 32-bit values. 0x28 is the DMA base and 0x2C is the DMA end.
- R6: Offsets 0x14 and 0x34 store only bit 0 and read it back with zeros above. Output link_en follows bit 0 of offset 0x14.
- R7: With the DMA enable set, dma_hit is 1 exactly when base <= dma_addr < end, compared unsigned.
- R8: While bit 0 of offset 0x34 is 0, dma_hit is 0 for every address.
- R9: A configuration access with cfg_bus 0 and cfg_devfn 0 is passed on. A read raises cfg_dev_rd, and a write raises cfg_dev_wr. cfg_rdata is cfg_dev_rdata masked to the access width. Size codes are 0 for byte, 1 for half-word, and 2 or 3 for word.
- R10: A configuration access to any other bus or devfn raises neither strobe. cfg_rdata is then 0x000000FF, 0x0000FFFF or 0xFFFFFFFF according to the size code.
- R11: A key write while open returns the block to arming. All window and enable registers read 0 after that edge, and offset 0x18 reads 1 again UNLOCK_DELAY edges later.
- R12: Offsets 0x10, 0x1C, 0x30, 0x38, 0x3C and every unaligned offset above 0x0F read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| link_en | output | 1 | Bridge enable (bit 0 of offset 0x14) |
| cfg_req | input | 1 | Configuration access request |
| cfg_we | input | 1 | Configuration access is a write |
| cfg_bus | input | 8 | Target bus number |
| cfg_devfn | input | 8 | Target device/function |
| cfg_size | input | 2 | Access width code |
| cfg_dev_rdata | input | 32 | Read data returned by the attached device |
| cfg_dev_rd | output | 1 | Forwarded configuration read strobe |
| cfg_dev_wr | output | 1 | Forwarded configuration write strobe |
| cfg_rdata | output | 32 | Configuration read result |
| dma_addr | input | 32 | Address checked against the DMA window |
| dma_hit | output | 1 | Address lies in the enabled DMA window |

## Verification
The hardest situations to reach from the ports are the edges of the unlock delay and the rekey path from the open state.

For the delay, the bench writes the key and then samples offset 0x18 at every cycle of the count. This pins the first cycle in which it reads 1.

For the rekey path, the bench first fills every register. It then writes the key again and confirms that all registers read zero and that the count runs once more.

Registers written while locked and while arming are read back after the unlock completes, to show the writes were lost.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMING = 2'd1,
        ST_OPEN   = 2'd2
    } ulk_state_t;

    localparam logic [5:0] OFS_LINK_EN = 6'h14;
    localparam logic [5:0] OFS_UNLOCK  = 6'h18;
    localparam logic [5:0] OFS_WIN0    = 6'h20;
    localparam logic [5:0] OFS_WIN1    = 6'h24;
    localparam logic [5:0] OFS_DMA_LO  = 6'h28;
    localparam logic [5:0] OFS_DMA_HI  = 6'h2C;
    localparam logic [5:0] OFS_DMA_EN  = 6'h34;
endpackage

// File: rtl/bridge_unlock_fsm.sv
module bridge_unlock_fsm
    import bridge_pkg::*;
#(
    parameter int UNLOCK_DELAY = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_hit,
    output ulk_state_t state_o,
    output logic       clr_o
);
    localparam int CW = (UNLOCK_DELAY > 1) ? $clog2(UNLOCK_DELAY) : 1;
    localparam logic [CW-1:0] LOAD = CW'(UNLOCK_DELAY - 1);

    ulk_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        clr_o   = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (key_hit) begin          // key_write
                    state_d = ST_ARMING;
                    cnt_d   = LOAD;
                end
            end
            ST_ARMING: begin
                if (key_hit) begin          // restart
                    cnt_d = LOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_OPEN;      // delay_done
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_OPEN: begin
                if (key_hit) begin          // rekey
                    state_d = ST_ARMING;
                    cnt_d   = LOAD;
                    clr_o   = 1'b1;
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/bridge_cfg_filter.sv
module bridge_cfg_filter #(
    parameter int DW = 32,
    parameter int BW = 8
) (
    input  logic          req,
    input  logic          we,
    input  logic [BW-1:0] bus,
    input  logic [BW-1:0] devfn,
    input  logic [1:0]    size,
    input  logic [DW-1:0] dev_rdata,
    output logic          dev_rd,
    output logic          dev_wr,
    output logic [DW-1:0] rdata
);
    logic          sel;
    logic [DW-1:0] mask;

    always_comb begin
        sel = (bus == '0) && (devfn == '0);
        unique case (size)
            2'd0:    mask = DW'(8'hFF);
            2'd1:    mask = DW'(16'hFFFF);
            default: mask = '1;
        endcase
        dev_rd = req && !we && sel;
        dev_wr = req && we && sel;
        rdata  = sel ? (dev_rdata & mask) : mask;
    end
endmodule

// File: rtl/bridge_dma_window.sv
module bridge_dma_window #(
    parameter int AW = 32
) (
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] lim,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic above_base, below_end;

    always_comb begin
        above_base = (addr >= base);
        below_end  = (addr < lim);
        hit        = en && above_base && below_end;
    end
endmodule

// File: rtl/bridge_ctl.sv
module bridge_ctl
    import bridge_pkg::*;
#(
    parameter int           UNLOCK_DELAY = 16,
    parameter logic [31:0]  UNLOCK_KEY   = 32'h5A14_A501,
    parameter logic [127:0] ID_STR       = "HOSTBUS-PCI-BR01"
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        link_en,
    input  logic        cfg_req,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_bus,
    input  logic [7:0]  cfg_devfn,
    input  logic [1:0]  cfg_size,
    input  logic [31:0] cfg_dev_rdata,
    output logic        cfg_dev_rd,
    output logic        cfg_dev_wr,
    output logic [31:0] cfg_rdata,
    input  logic [31:0] dma_addr,
    output logic        dma_hit
);
    localparam int ID_BYTES = 16;

    ulk_state_t  st;
    logic        key_hit, clr, wr_open;
    logic [31:0] win0_q, win1_q, dma_base_q, dma_end_q;
    logic        link_en_q, dma_en_q;

    assign key_hit = reg_wr && (reg_addr == OFS_UNLOCK) && (reg_wdata == UNLOCK_KEY);
    assign wr_open = reg_wr && (st == ST_OPEN);

    bridge_unlock_fsm #(.UNLOCK_DELAY(UNLOCK_DELAY)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_hit (key_hit),
        .state_o (st),
        .clr_o   (clr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            win0_q     <= '0;
            win1_q     <= '0;
            dma_base_q <= '0;
            dma_end_q  <= '0;
            link_en_q  <= 1'b0;
            dma_en_q   <= 1'b0;
        end else if (wr_open) begin
            unique case (reg_addr)
                OFS_WIN0:    win0_q     <= reg_wdata;
                OFS_WIN1:    win1_q     <= reg_wdata;
                OFS_DMA_LO:  dma_base_q <= reg_wdata;
                OFS_DMA_HI:  dma_end_q  <= reg_wdata;
                OFS_LINK_EN: link_en_q  <= reg_wdata[0];
                OFS_DMA_EN:  dma_en_q   <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < 6'(ID_BYTES)) begin
            reg_rdata = {24'h0, ID_STR[8*(ID_BYTES-1-int'(reg_addr[3:0])) +: 8]};
        end else begin
            unique case (reg_addr)
                OFS_UNLOCK:  reg_rdata = {31'h0, st == ST_OPEN};
                OFS_WIN0:    reg_rdata = win0_q;
                OFS_WIN1:    reg_rdata = win1_q;
                OFS_DMA_LO:  reg_rdata = dma_base_q;
                OFS_DMA_HI:  reg_rdata = dma_end_q;
                OFS_LINK_EN: reg_rdata = {31'h0, link_en_q};
                OFS_DMA_EN:  reg_rdata = {31'h0, dma_en_q};
                default:     reg_rdata = '0;
            endcase
        end
    end

    assign link_en = link_en_q;

    bridge_cfg_filter #(.DW(32), .BW(8)) u_cfg (
        .req       (cfg_req),
        .we        (cfg_we),
        .bus       (cfg_bus),
        .devfn     (cfg_devfn),
        .size      (cfg_size),
        .dev_rdata (cfg_dev_rdata),
        .dev_rd    (cfg_dev_rd),
        .dev_wr    (cfg_dev_wr),
        .rdata     (cfg_rdata)
    );

    bridge_dma_window #(.AW(32)) u_win (
        .en   (dma_en_q),
        .base (dma_base_q),
        .lim  (dma_end_q),
        .addr (dma_addr),
        .hit  (dma_hit)
    );
endmodule

// File: rtl/bridge_ctl_chk.sv
module bridge_ctl_chk
    import bridge_pkg::*;
#(
    parameter logic [31:0] KEY = 32'h5A14_A501
) (
    input logic        clk,
    input logic        rst_n,
    input ulk_state_t  st,
    input logic        reg_wr,
    input logic [5:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] dma_base_q,
    input logic        link_en,
    input logic        dma_en_q,
    input logic        dma_hit,
    input logic        cfg_req,
    input logic        cfg_we,
    input logic [1:0]  cfg_size,
    input logic        cfg_dev_rd,
    input logic [31:0] cfg_rdata
);
    // R2
    open_from_arming_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OPEN && $past(st) != ST_OPEN) |-> $past(st) == ST_ARMING);

    // R3
    bad_key_stays_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOCKED && reg_wr && reg_addr == OFS_UNLOCK && reg_wdata != KEY)
        |=> st == ST_LOCKED);

    // R4
    locked_base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OPEN) |=> $stable(dma_base_q));

    // R4
    locked_link_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OPEN) |=> $stable(link_en));

    // R8
    hit_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_q |-> !dma_hit);

    // R10
    byte_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we && !cfg_dev_rd && cfg_size == 2'd0) |-> cfg_rdata == 32'h0000_00FF);
endmodule

bind bridge_ctl bridge_ctl_chk #(.KEY(UNLOCK_KEY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .dma_base_q (dma_base_q),
    .link_en    (link_en),
    .dma_en_q   (dma_en_q),
    .dma_hit    (dma_hit),
    .cfg_req    (cfg_req),
    .cfg_we     (cfg_we),
    .cfg_size   (cfg_size),
    .cfg_dev_rd (cfg_dev_rd),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/tb_bridge_ctl.sv
`timescale 1ns/1ps
module tb_bridge_ctl;
    localparam int D = 16;
    localparam logic [31:0] KEY = 32'h5A14_A501;
    localparam logic [127:0] IDV = "HOSTBUS-PCI-BR01";

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_en;
    logic        cfg_req = 1'b0, cfg_we = 1'b0;
    logic [7:0]  cfg_bus = '0, cfg_devfn = '0;
    logic [1:0]  cfg_size = '0;
    logic [31:0] cfg_dev_rdata = '0;
    logic        cfg_dev_rd, cfg_dev_wr;
    logic [31:0] cfg_rdata;
    logic [31:0] dma_addr = '0;
    logic        dma_hit;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bridge_ctl #(.UNLOCK_DELAY(D)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_en(link_en),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
        .cfg_size(cfg_size), .cfg_dev_rdata(cfg_dev_rdata), .cfg_dev_rd(cfg_dev_rd),
        .cfg_dev_wr(cfg_dev_wr), .cfg_rdata(cfg_rdata), .dma_addr(dma_addr), .dma_hit(dma_hit)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic unlock_timed(input string tag);
        wr(6'h18, KEY);
        rd_chk(tag, 6'h18, 32'd0);
        repeat (D - 1) @(negedge clk);
        rd_chk(tag, 6'h18, 32'd0);
        @(negedge clk);
        rd_chk(tag, 6'h18, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [5:0] offs [6];
        offs = '{6'h14, 6'h20, 6'h24, 6'h28, 6'h2C, 6'h34};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd_chk("R2 reset unlock", 6'h18, 32'd0);
        for (int i = 0; i < 6; i++) rd_chk("R4 reset reg", offs[i], 32'd0);
        chk("R6 reset link_en", {31'h0, link_en}, 32'd0);
        dma_addr = 32'h0; #1;
        chk("R8 reset hit", {31'h0, dma_hit}, 32'd0);

        // R1 identification sweep
        for (int i = 0; i < 16; i++)
            rd_chk("R1 id byte", 6'(i), {24'h0, IDV[8*(15-i) +: 8]});

        // R12 unused offsets
        rd_chk("R12 0x10", 6'h10, 0);
        rd_chk("R12 0x1C", 6'h1C, 0);
        rd_chk("R12 0x30", 6'h30, 0);
        rd_chk("R12 0x38", 6'h38, 0);
        rd_chk("R12 0x3C", 6'h3C, 0);
        rd_chk("R12 0x21", 6'h21, 0);

        // R4 writes while locked
        for (int i = 0; i < 6; i++) wr(offs[i], 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) rd_chk("R4 locked write", offs[i], 32'd0);
        chk("R4 locked link_en", {31'h0, link_en}, 32'd0);

        // R3 wrong key
        wr(6'h18, KEY ^ 32'h1);
        repeat (D + 4) @(negedge clk);
        rd_chk("R3 bad key", 6'h18, 32'd0);

        // R2 exact delay
        unlock_timed("R2 delay");

        // R3 non-key write while open
        wr(6'h18, 32'h0);
        rd_chk("R3 open non-key", 6'h18, 32'd1);

        // R5 R6 store and read back
        wr(6'h20, 32'h0100_0000);
        wr(6'h24, 32'hDEAD_BEEF);
        wr(6'h28, 32'h0184_0000);
        wr(6'h2C, 32'h0184_8000);
        wr(6'h14, 32'hFFFF_FFFF);
        rd_chk("R5 win0", 6'h20, 32'h0100_0000);
        rd_chk("R5 win1", 6'h24, 32'hDEAD_BEEF);
        rd_chk("R5 base", 6'h28, 32'h0184_0000);
        rd_chk("R5 end", 6'h2C, 32'h0184_8000);
        rd_chk("R6 link reg", 6'h14, 32'd1);
        chk("R6 link_en", {31'h0, link_en}, 32'd1);
        wr(6'h14, 32'hFFFF_FFFE);
        rd_chk("R6 link cleared", 6'h14, 32'd0);
        chk("R6 link_en low", {31'h0, link_en}, 32'd0);

        // R7 R8 window sweep, enable off then on
        for (int en = 0; en < 2; en++) begin
            logic [31:0] pts [10];
            pts = '{32'h0, 32'h0183_FFFF, 32'h0184_0000, 32'h0184_0001, 32'h0184_4000,
                    32'h0184_7FFF, 32'h0184_8000, 32'h0184_8001, 32'h8000_0000, 32'hFFFF_FFFF};
            wr(6'h34, 32'(en));
            rd_chk("R6 dma en reg", 6'h34, 32'(en));
            for (int k = 0; k < 10; k++) begin
                logic exp_hit;
                exp_hit = (en == 1) && (pts[k] >= 32'h0184_0000) && (pts[k] < 32'h0184_8000);
                dma_addr = pts[k];
                #1;
                chk(en == 1 ? "R7 window" : "R8 disabled", {31'h0, dma_hit}, {31'h0, exp_hit});
            end
        end

        // R9 R10 configuration sweep
        begin
            logic [7:0] buses [3];
            logic [7:0] dfs [4];
            buses = '{8'h00, 8'h01, 8'hFF};
            dfs   = '{8'h00, 8'h01, 8'h08, 8'hFF};
            for (int b = 0; b < 3; b++)
                for (int f = 0; f < 4; f++)
                    for (int s = 0; s < 4; s++)
                        for (int w = 0; w < 2; w++) begin
                            logic sel;
                            logic [31:0] m, exp_rd;
                            sel = (buses[b] == 0) && (dfs[f] == 0);
                            m = (s == 0) ? 32'hFF : (s == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
                            cfg_req = 1'b1; cfg_we = w[0];
                            cfg_bus = buses[b]; cfg_devfn = dfs[f]; cfg_size = 2'(s);
                            cfg_dev_rdata = 32'hA5C3_1E77 ^ {24'h0, 8'(b * 16 + f * 4 + s)};
                            exp_rd = sel ? (cfg_dev_rdata & m) : m;
                            #1;
                            chk(sel ? "R9 fwd rd" : "R10 drop rd", {31'h0, cfg_dev_rd},
                                {31'h0, sel && (w == 0)});
                            chk(sel ? "R9 fwd wr" : "R10 drop wr", {31'h0, cfg_dev_wr},
                                {31'h0, sel && (w == 1)});
                            if (w == 0) chk(sel ? "R9 rdata" : "R10 ones", cfg_rdata, exp_rd);
                            @(negedge clk);
                        end
            cfg_req = 1'b0;
        end

        // R11 rekey clears and rearms
        wr(6'h14, 32'd1);
        unlock_timed("R11 rekey delay");
        for (int i = 0; i < 6; i++) rd_chk("R11 cleared", offs[i], 32'd0);
        chk("R11 link_en", {31'h0, link_en}, 32'd0);

        // R4 write during arming is lost
        wr(6'h18, KEY);
        wr(6'h28, 32'h1234_5678);
        repeat (D + 2) @(negedge clk);
        rd_chk("R4 arming write", 6'h28, 32'd0);
        rd_chk("R2 reopened", 6'h18, 32'd1);
        wr(6'h28, 32'h1234_5678);
        rd_chk("R5 write after reopen", 6'h28, 32'h1234_5678);

        finish_run();
    end
endmodule